// File: doc/BRIEF.md
# Lane Predication Enable Stack

This block holds the predication state for an array of identical processing lanes that all execute the same instruction in lockstep. Each lane has its own stack of enable bits. The lanes share one stack pointer. A lane takes part in lane-side work only when every bit below the pointer is one. A sequencer drives one operation per clock. The operations are: push a per-lane condition, pop, flip the top level for an else clause, open a per-lane function, disable returning lanes, and close the function. The block reports the per-lane enable vector and a flag that is high while any lane is enabled. The sequencer uses that flag to end data-dependent loops.

A function call records the current depth as a frame marker and pushes an all-ones level. A return clears that level's bit in the lanes that are enabled at that moment, so those lanes stay idle for the rest of the body. The exit drops the stack back to the marker, which restores the enables that held at entry. Pushes past the configured depth set a sticky overflow error. Pops or flips below the current floor, and returns or exits with no open frame, set a sticky underflow error. A faulting operation does not change the stack state.

Top module: `pred_enable_stack`

## Requirements
- R1: After reset all stacks are empty, `en_o` is all ones, `any_en_o` is 1, and both error flags are 0.
- R2: Operation code 1 (push) places `cond_i[l]` on top of lane l's stack. A lane is enabled only while every bit on its stack is 1, so pushing a 0 disables that lane.
- R3: Operation code 2 (pop) removes the top level and restores the enables that held before the matching push.
- R4: Operation code 3 (else) inverts the top level on every lane and leaves the lower levels unchanged.
- R5: `any_en_o` is 1 exactly when at least one bit of `en_o` is 1.
- R6: Operation code 4 (call) records the current depth as a frame marker and pushes an all-ones level, so no enable changes.
- R7: Operation code 5 (return) clears the frame level's bit only in the lanes that are enabled at that moment. Lanes that are already disabled are unaffected.
- R8: Operation code 6 (exit) sets the depth back to the innermost frame marker and closes that frame, which restores the enables that held before the call.
- R9: A push or call with the stack at depth DEPTH sets `overflow_o`, which stays set until reset, and leaves the enables and the depth unchanged.
- R10: A pop or else at the floor (depth 0, or the level just above the innermost frame marker), or a return or exit with no open frame, sets `underflow_o`, which stays set until reset, and leaves the state unchanged.
- R11: Codes 0 and 7 are no-operations. Each operation's effect appears on `en_o` after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Operation code: 0 nop, 1 push, 2 pop, 3 else, 4 call, 5 return, 6 exit, 7 nop |
| cond_i | input | NUM_LANES | Per-lane condition for push |
| en_o | output | NUM_LANES | Registered per-lane enable |
| any_en_o | output | 1 | High when any lane is enabled |
| overflow_o | output | 1 | Sticky overflow error |
| underflow_o | output | 1 | Sticky underflow error |

## Verification
On every cycle the assertions check several things. The error flags must stay set once raised, and a faulting push must leave the depth untouched. A valid push must raise the depth by one and a pop must lower it by one. An exit must land on the recorded marker. A lane that pushes a zero, or that is enabled when a return arrives, must be disabled on the next cycle. Some behaviours appear only in the bench scenarios. These are the full enable patterns produced by nested else clauses, the restoration of entry state after a return and exit, and agreement with an independent reference model over long random sequences of nested operations.

// File: rtl/pred_stack_pkg.sv
package pred_stack_pkg;
  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_PUSH = 3'd1,
    OP_POP  = 3'd2,
    OP_ELSE = 3'd3,
    OP_CALL = 3'd4,
    OP_RET  = 3'd5,
    OP_EXIT = 3'd6
  } pred_op_e;
endpackage

// File: rtl/pred_lane_column.sv
module pred_lane_column #(
  parameter int DEPTH = 8,
  parameter int SPW   = $clog2(DEPTH + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wr_i,
  input  logic           wr_bit_i,
  input  logic           flip_i,
  input  logic           clr_i,
  input  logic [SPW-1:0] idx_i,
  input  logic [SPW-1:0] depth_d_i,
  output logic           en_o
);
  logic [DEPTH-1:0] bits_q, bits_d, live;
  logic             en_q;

  always_comb begin
    bits_d = bits_q;
    for (int k = 0; k < DEPTH; k++) begin
      if (idx_i == SPW'(k)) begin
        if (wr_i)          bits_d[k] = wr_bit_i;
        if (flip_i)        bits_d[k] = ~bits_q[k];
        if (clr_i && en_q) bits_d[k] = 1'b0;  // only lanes running now
      end
      live[k] = SPW'(k) < depth_d_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bits_q <= '1;
      en_q   <= 1'b1;
    end else begin
      bits_q <= bits_d;
      en_q   <= &(bits_d | ~live);
    end
  end

  assign en_o = en_q;

  p_zero_push_blocks_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !wr_bit_i) |=> !en_o);
  p_ret_disables_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && en_o) |=> !en_o);
endmodule

// File: rtl/pred_frame_stack.sv
module pred_frame_stack #(
  parameter int FRAMES = 8,
  parameter int SPW    = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           push_i,
  input  logic           pop_i,
  input  logic [SPW-1:0] mark_i,
  output logic [SPW-1:0] mark_o,
  output logic           active_o
);
  localparam int CW = $clog2(FRAMES + 1);

  logic [SPW-1:0] marks_q [FRAMES];
  logic [CW-1:0]  cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      for (int k = 0; k < FRAMES; k++) marks_q[k] <= '0;
    end else if (push_i) begin
      for (int k = 0; k < FRAMES; k++)
        if (cnt_q == CW'(k)) marks_q[k] <= mark_i;
      cnt_q <= cnt_q + 1'b1;
    end else if (pop_i) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  always_comb begin
    mark_o = '0;
    for (int k = 0; k < FRAMES; k++)
      if (cnt_q == CW'(k + 1)) mark_o = marks_q[k];
  end

  assign active_o = cnt_q != '0;

  p_frame_bounds_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pop_i && !active_o) && (cnt_q <= CW'(FRAMES)));
endmodule

// File: rtl/pred_enable_stack.sv
module pred_enable_stack
  import pred_stack_pkg::*;
#(
  parameter int NUM_LANES = 8,
  parameter int DEPTH     = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [2:0]           op_i,
  input  logic [NUM_LANES-1:0] cond_i,
  output logic [NUM_LANES-1:0] en_o,
  output logic                 any_en_o,
  output logic                 overflow_o,
  output logic                 underflow_o
);
  localparam int SPW = $clog2(DEPTH + 1);

  logic [SPW-1:0] sp_q, sp_d, idx, mark, floor_lvl;
  logic           active, ovf_q, unf_q;
  logic           is_push, is_pop, is_else, is_call, is_ret, is_exit;
  logic           ovf_evt, unf_evt, full, above_floor;
  logic           do_push, do_pop, do_else, do_call, do_ret, do_exit;

  assign is_push = op_i == OP_PUSH;
  assign is_pop  = op_i == OP_POP;
  assign is_else = op_i == OP_ELSE;
  assign is_call = op_i == OP_CALL;
  assign is_ret  = op_i == OP_RET;
  assign is_exit = op_i == OP_EXIT;

  assign full        = sp_q == SPW'(DEPTH);
  assign floor_lvl   = active ? mark + 1'b1 : '0;
  assign above_floor = sp_q > floor_lvl;

  assign ovf_evt = (is_push || is_call) && full;
  assign unf_evt = ((is_pop || is_else) && !above_floor) ||
                   ((is_ret || is_exit) && !active);

  assign do_push = is_push && !full;
  assign do_call = is_call && !full;
  assign do_pop  = is_pop  && above_floor;
  assign do_else = is_else && above_floor;
  assign do_ret  = is_ret  && active;
  assign do_exit = is_exit && active;

  always_comb begin
    sp_d = sp_q;
    idx  = sp_q;
    if (do_push || do_call) sp_d = sp_q + 1'b1;
    if (do_pop)             sp_d = sp_q - 1'b1;
    if (do_exit)            sp_d = mark;
    if (do_else)            idx  = sp_q - 1'b1;
    if (do_ret)             idx  = mark;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_q  <= '0;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      sp_q  <= sp_d;
      ovf_q <= ovf_q | ovf_evt;
      unf_q <= unf_q | unf_evt;
    end
  end

  pred_frame_stack #(.FRAMES(DEPTH), .SPW(SPW)) u_frames (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .push_i   (do_call),
    .pop_i    (do_exit),
    .mark_i   (sp_q),
    .mark_o   (mark),
    .active_o (active)
  );

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    pred_lane_column #(.DEPTH(DEPTH), .SPW(SPW)) u_col (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_i      (do_push || do_call),
      .wr_bit_i  (do_call ? 1'b1 : cond_i[l]),
      .flip_i    (do_else),
      .clr_i     (do_ret),
      .idx_i     (idx),
      .depth_d_i (sp_d),
      .en_o      (en_o[l])
    );
  end

  assign any_en_o    = |en_o;
  assign overflow_o  = ovf_q;
  assign underflow_o = unf_q;

  p_push_depth_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_push && !full) |=> sp_q == $past(sp_q) + 1'b1);
  p_pop_depth_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_pop |=> sp_q == $past(sp_q) - 1'b1);
  p_exit_depth_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_exit |=> sp_q == $past(mark));
  p_no_overflow_move_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_evt |=> (sp_q == $past(sp_q)) && overflow_o);
  p_overflow_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o);
  p_underflow_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underflow_o |=> underflow_o);
endmodule

// File: tb/tb_pred_enable_stack.sv
module tb_pred_enable_stack;
  localparam int N = 8;
  localparam int D = 8;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [2:0]   op_i = 3'd0;
  logic [N-1:0] cond_i = '0;
  logic [N-1:0] en_o;
  logic         any_en_o, overflow_o, underflow_o;

  int total = 0;
  int bad   = 0;

  pred_enable_stack #(.NUM_LANES(N), .DEPTH(D)) dut (
    .clk_i, .rst_ni, .op_i, .cond_i, .en_o, .any_en_o, .overflow_o, .underflow_o
  );

  always #5 clk_i = ~clk_i;

  // reference model
  bit m_stk [D][N];
  int m_sp, m_fc;
  int m_mark [D];
  bit m_ovf, m_unf;

  function automatic logic [N-1:0] m_en();
    logic [N-1:0] e;
    for (int l = 0; l < N; l++) begin
      e[l] = 1'b1;
      for (int k = 0; k < m_sp; k++) e[l] &= m_stk[k][l];
    end
    return e;
  endfunction

  task automatic m_clear();
    m_sp = 0; m_fc = 0; m_ovf = 0; m_unf = 0;
  endtask

  task automatic m_step(input logic [2:0] op, input logic [N-1:0] c);
    int fl;
    logic [N-1:0] cur;
    fl  = (m_fc > 0) ? m_mark[m_fc-1] + 1 : 0;
    cur = m_en();
    case (op)
      3'd1, 3'd4: if (m_sp == D) m_ovf = 1;
                  else begin
                    if (op == 3'd4) begin m_mark[m_fc] = m_sp; m_fc++; end
                    for (int l = 0; l < N; l++) m_stk[m_sp][l] = (op == 3'd4) ? 1'b1 : c[l];
                    m_sp++;
                  end
      3'd2: if (m_sp <= fl) m_unf = 1; else m_sp--;
      3'd3: if (m_sp <= fl) m_unf = 1;
            else for (int l = 0; l < N; l++) m_stk[m_sp-1][l] = ~m_stk[m_sp-1][l];
      3'd5: if (m_fc == 0) m_unf = 1;
            else for (int l = 0; l < N; l++) if (cur[l]) m_stk[m_mark[m_fc-1]][l] = 1'b0;
      3'd6: if (m_fc == 0) m_unf = 1;
            else begin m_sp = m_mark[m_fc-1]; m_fc--; end
      default: ;
    endcase
  endtask

  task automatic chk(input string tag, input logic [N-1:0] ee, input logic ea,
                     input logic eo, input logic eu);
    total++;
    if (en_o !== ee || any_en_o !== ea || overflow_o !== eo || underflow_o !== eu) begin
      bad++;
      $display("FAIL %s: en=%h any=%b ovf=%b unf=%b expected en=%h any=%b ovf=%b unf=%b",
               tag, en_o, any_en_o, overflow_o, underflow_o, ee, ea, eo, eu);
    end
  endtask

  task automatic chk_model(input string tag);
    logic [N-1:0] e;
    e = m_en();
    chk(tag, e, |e, m_ovf, m_unf);
  endtask

  // drive at negedge, result visible at following negedge (R11)
  task automatic step(input logic [2:0] op, input logic [N-1:0] c);
    op_i = op; cond_i = c;
    m_step(op, c);
    @(negedge clk_i);
    op_i = 3'd0; cond_i = '0;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    m_clear();
    @(negedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  // {op, cond, expected en, expected any}
  localparam logic [19:0] VEC [15] = '{
    {3'd1, 8'h0F, 8'h0F, 1'b1},  // R2
    {3'd1, 8'h33, 8'h03, 1'b1},  // R2 nesting
    {3'd3, 8'h00, 8'h0C, 1'b1},  // R4
    {3'd2, 8'h00, 8'h0F, 1'b1},  // R3
    {3'd3, 8'h00, 8'hF0, 1'b1},  // R4
    {3'd1, 8'h00, 8'h00, 1'b0},  // R5 none enabled
    {3'd2, 8'h00, 8'hF0, 1'b1},  // R3
    {3'd4, 8'h00, 8'hF0, 1'b1},  // R6
    {3'd1, 8'h30, 8'h30, 1'b1},
    {3'd5, 8'h00, 8'h00, 1'b0},  // R7
    {3'd2, 8'h00, 8'hC0, 1'b1},  // R7 returned lanes stay off
    {3'd6, 8'h00, 8'hF0, 1'b1},  // R8
    {3'd2, 8'h00, 8'hFF, 1'b1},
    {3'd0, 8'hAA, 8'hFF, 1'b1},  // R11
    {3'd7, 8'h55, 8'hFF, 1'b1}   // R11
  };

  initial begin
    repeat (150000) @(posedge clk_i);
    total++; bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    chk("R1 reset", '1, 1'b1, 1'b0, 1'b0);

    for (int i = 0; i < 15; i++) begin
      step(VEC[i][19:17], VEC[i][16:9]);
      chk($sformatf("R11 table row %0d", i), VEC[i][8:1], VEC[i][0], 1'b0, 1'b0);
    end

    // R9 overflow
    do_reset();
    for (int i = 0; i < D; i++) step(3'd1, '1);
    step(3'd1, '0);
    chk("R9 overflow push", '1, 1'b1, 1'b1, 1'b0);
    step(3'd4, '0);
    step(3'd2, '0);
    chk("R9 overflow sticky", '1, 1'b1, 1'b1, 1'b0);
    do_reset();
    chk("R1 reset clears errors", '1, 1'b1, 1'b0, 1'b0);

    // R10 underflow cases
    step(3'd2, '0);
    chk("R10 pop empty", '1, 1'b1, 1'b0, 1'b1);
    do_reset();
    step(3'd3, '0);
    chk("R10 else empty", '1, 1'b1, 1'b0, 1'b1);
    do_reset();
    step(3'd5, '0);
    chk("R10 return no frame", '1, 1'b1, 1'b0, 1'b1);
    do_reset();
    step(3'd1, 8'h3C);
    step(3'd4, '0);
    step(3'd2, '0);
    chk("R10 pop at frame floor", 8'h3C, 1'b1, 1'b0, 1'b1);
    step(3'd6, '0);
    step(3'd2, '0);
    chk("R10 state kept after fault", '1, 1'b1, 1'b0, 1'b1);

    // random nested sequences against the model (R2..R10, R5)
    do_reset();
    for (int i = 0; i < 4000; i++) begin
      int r;
      logic [2:0] op;
      r = int'($urandom_range(99));
      if (r < 30) op = 3'd1;
      else if (r < 50) op = 3'd2;
      else if (r < 65) op = 3'd3;
      else if (r < 75) op = 3'd4;
      else if (r < 85) op = 3'd5;
      else if (r < 95) op = 3'd6;
      else op = 3'd0;
      step(op, N'($urandom));
      chk_model("R5 random model");
      if (i % 250 == 249) do_reset();
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule